// File: doc/BRIEF.md
# Audio DMA Channel Descriptor Controller

This block is the register and sequencing core of one audio DMA channel. Software places a ring of up to 32 buffer descriptors in memory. Each descriptor is 8 bytes long: a buffer pointer at byte 0 and a control word at byte 4. Software then programs the ring base and a last-valid index and sets the run bit. A separate data mover moves the samples. Each time it finishes a buffer it pulses `bufDone`. The channel then reads the finished descriptor's control word to learn whether an interrupt was requested. It either stops at the last-valid entry or advances to the next entry, and it reads the new entry's control word to load the remaining sample count.

The channel stops when it reaches the last-valid entry. Software can keep it fed by moving the last-valid index forward. A write that moves the index away from the current entry while the channel is running but halted restarts the channel with no other register access. The event bits in the status register are cleared by writing a one to them. The interrupt output is recomputed only when one of those event bits changes.

The register port works on dwords with byte enables. Dword 0 holds the ring base. Dword 1 holds four bytes: current index (byte 0), last-valid index (byte 1), prefetch index (byte 2) and control (byte 3). Dword 2 holds status in bits [4:0] and the remaining count in bits [31:16]. Control bits are: run = bit 0, reset-registers = bit 1 (self-clearing, reads 0), last-buffer interrupt enable = bit 2, buffer-complete interrupt enable = bit 3. Status bits are: halted = bit 0, current-at-last = bit 1, last-buffer-done = bit 2, buffer-complete = bit 3, FIFO error = bit 4.

Top module: `desc_ring_channel`

## Requirements
- R1: After reset the ring base, all three indices, the control byte and the remaining count read 0, status reads 0x0001, `irq` is low and no descriptor read is requested.
- R2: A write to the ring base honours the byte enables and always stores bits [2:0] as zero.
- R3: The last-valid index stores the written byte modulo 32. Writes to the current index, the prefetch index and the remaining count have no effect.
- R4: Status bits 2, 3 and 4 are cleared by writing a one to them. Writing zeros leaves them unchanged, and bits 0 and 1 ignore all writes. A pulse on `fifoErr` sets bit 4.
- R5: Writing run = 1 while run is 0 sets current index to 0 and prefetch index to 1 and clears halted. Writing run = 0 sets halted.
- R6: Writing control with bit 1 set reinitialises base, indices, control and count to 0 and status to 0x0001, and `irq` drops.
- R7: A `bufDone` pulse accepted while run = 1 and halted = 0 raises `descReqValid` in the next cycle with address base + 8*current + 4. The request is held until `descRspValid`.
- R8: If a completed entry is not the last-valid one, buffer-complete is set when bit 31 of its control word is 1 and is left unchanged when bit 31 is 0. Current-at-last is cleared. The current index takes the old prefetch value and the prefetch index becomes that value + 1 modulo 32. A second read of the new entry loads bits [15:0] of its control word into the remaining count.
- R9: If the completed entry is the last-valid one, halted, current-at-last and last-buffer-done are set, the indices do not change, and the count is loaded from that same response.
- R10: A last-valid write while run = 1, halted = 1 and the new value differs from the current index advances the indices and clears halted and current-at-last. It then fetches the new entry's count at base + 8*current + 4.
- R11: `irq` is recomputed only when status bits 2 to 4 change. It is high when (bit 2 and enable bit 2) or (bit 3 and enable bit 3), and low otherwise. A change to the enable bits alone does not move it.
- R12: When a completion sets a status bit in the same cycle that a write-one-to-clear targets that bit, the set wins.
- R13: `bufDone` is ignored when run = 0 or halted = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regDword | input | 2 | Dword select of the register access |
| regByteEn | input | 4 | Byte enables of the write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected dword, combinational |
| bufDone | input | 1 | Data mover finished the current buffer |
| fifoErr | input | 1 | Data mover reports a FIFO fault |
| descReqValid | output | 1 | Descriptor control-word read request |
| descReqAddr | output | ADDR_W | Byte address of the requested word |
| descRspValid | input | 1 | Read response valid |
| descRspData | input | 32 | Read response data |
| irq | output | 1 | Channel interrupt level |

## Verification
Two functions can fall in the same cycle. One is the completion update, which sets buffer-complete from a descriptor response. The other is a software write-one-to-clear aimed at that same bit. The bench provokes the collision by driving `descRspValid` and the status clear write on the same clock edge. It then checks that buffer-complete stays set, together with the halted and last-buffer bits and the loaded count. It also checks that `irq` rises, which shows that the event was not lost.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  localparam int CNT_W = 16;

  localparam int ST_HALTED  = 0;
  localparam int ST_ATLAST  = 1;
  localparam int ST_LASTBUF = 2;
  localparam int ST_BUFDONE = 3;
  localparam int ST_FIFOERR = 4;
  localparam int ST_W       = 5;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_WAIT_DONE,
    FS_WAIT_NEXT
  } fetchState_t;

  typedef struct packed {
    logic [3:0] baseByteEn;
    logic       wrLvi;
    logic       wrCtrl;
    logic       regReset;
    logic       start;
    logic       stop;
    logic       restart;
    logic [2:0] w1cMask;
    logic       complete;
    logic       ioc;
    logic       advance;
    logic       loadCount;
  } chanStrobes_t;

endpackage

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regDword,
  input  logic [3:0]       regByteEn,
  input  logic             wrRun,
  input  logic             wrRegReset,
  input  logic [2:0]       wrW1c,
  input  logic [IDX_W-1:0] wrLviVal,
  input  logic             bufDone,
  input  logic             descRspValid,
  input  logic             rspIoc,
  input  logic             runQ,
  input  logic             haltedQ,
  input  logic [IDX_W-1:0] civQ,
  input  logic [IDX_W-1:0] lviQ,
  output chanStrobes_t     strobes,
  output logic             descReqValid
);

  fetchState_t stateQ, stateD;
  logic wrDw0, wrDw1, wrDw2, atLast, idle, rspTaken;

  assign wrDw0    = regWrEn && regDword == 2'd0;
  assign wrDw1    = regWrEn && regDword == 2'd1;
  assign wrDw2    = regWrEn && regDword == 2'd2;
  assign atLast   = civQ == lviQ;
  assign idle     = stateQ == FS_IDLE;
  assign rspTaken = !idle && descRspValid;

  always_comb begin
    strobes            = '0;
    strobes.baseByteEn = wrDw0 ? regByteEn : 4'b0;
    strobes.regReset   = wrDw1 && regByteEn[3] && wrRegReset;
    strobes.wrCtrl     = wrDw1 && regByteEn[3] && !wrRegReset;
    strobes.wrLvi      = wrDw1 && regByteEn[1];
    strobes.stop       = strobes.wrCtrl && !wrRun;
    strobes.start      = strobes.wrCtrl && wrRun && !runQ;
    strobes.w1cMask    = (wrDw2 && regByteEn[0]) ? wrW1c : 3'b0;
    strobes.restart    = idle && strobes.wrLvi && !strobes.wrCtrl && !strobes.regReset
                         && runQ && haltedQ && (civQ != wrLviVal);
    strobes.complete   = stateQ == FS_WAIT_DONE && descRspValid && !strobes.regReset;
    strobes.ioc        = rspIoc;
    strobes.advance    = (strobes.complete && !atLast) || strobes.restart;
    strobes.loadCount  = rspTaken && !strobes.regReset
                         && (stateQ == FS_WAIT_NEXT || atLast);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      FS_IDLE: begin
        if (bufDone && runQ && !haltedQ) stateD = FS_WAIT_DONE;
        else if (strobes.restart)        stateD = FS_WAIT_NEXT;
      end
      FS_WAIT_DONE: if (descRspValid) stateD = atLast ? FS_IDLE : FS_WAIT_NEXT;
      FS_WAIT_NEXT: if (descRspValid) stateD = FS_IDLE;
      default:      stateD = FS_IDLE;
    endcase
    if (strobes.regReset) stateD = FS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= FS_IDLE;
    else       stateQ <= stateD;
  end

  assign descReqValid = !idle;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    descReqValid && !descRspValid && !strobes.regReset |=> descReqValid); // R7

  AST_IGNORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    idle && bufDone && (!runQ || haltedQ) && !strobes.restart |=> !descReqValid); // R13

endmodule

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobes_t      strobes,
  input  logic [1:0]        regDword,
  input  logic [31:0]       regWrData,
  input  logic [CNT_W-1:0]  rspCount,
  input  logic              fifoErr,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] descReqAddr,
  output logic              runQ,
  output logic              haltedQ,
  output logic [IDX_W-1:0]  civQ,
  output logic [IDX_W-1:0]  lviQ,
  output logic              irq
);

  localparam int DESC_SHIFT = 3;
  localparam int CTRL_OFF   = 4;
  localparam int IDX_PAD    = 8 - IDX_W;

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  pivQ;
  logic [CNT_W-1:0]  countQ;
  logic [ST_W-1:0]   statusQ, statusD;
  logic              lastEnQ, doneEnQ, lastEnD, doneEnD, irqQ, irqD, atLast;
  logic              unusedWr;

  assign unusedWr = ^regWrData[1:0];
  assign atLast   = civQ == lviQ;

  always_comb begin
    statusD = statusQ;
    lastEnD = strobes.wrCtrl ? regWrData[26] : lastEnQ;
    doneEnD = strobes.wrCtrl ? regWrData[27] : doneEnQ;
    if (strobes.regReset) begin
      statusD = ST_W'(1);
      lastEnD = 1'b0;
      doneEnD = 1'b0;
    end else begin
      statusD[ST_FIFOERR:ST_LASTBUF] = statusQ[ST_FIFOERR:ST_LASTBUF] & ~strobes.w1cMask;
      if (strobes.stop)  statusD[ST_HALTED] = 1'b1;
      if (strobes.start) statusD[ST_HALTED] = 1'b0;
      if (strobes.restart) begin
        statusD[ST_HALTED] = 1'b0;
        statusD[ST_ATLAST] = 1'b0;
      end
      if (fifoErr) statusD[ST_FIFOERR] = 1'b1;
      if (strobes.complete) begin
        statusD[ST_ATLAST] = 1'b0;
        if (strobes.ioc) statusD[ST_BUFDONE] = 1'b1;
        if (atLast) begin
          statusD[ST_HALTED]  = 1'b1;
          statusD[ST_ATLAST]  = 1'b1;
          statusD[ST_LASTBUF] = 1'b1;
        end
      end
    end
    if (statusD[ST_FIFOERR:ST_LASTBUF] != statusQ[ST_FIFOERR:ST_LASTBUF])
      irqD = (statusD[ST_LASTBUF] && lastEnD) || (statusD[ST_BUFDONE] && doneEnD);
    else
      irqD = irqQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.regReset) begin
      baseQ   <= '0;
      civQ    <= '0;
      pivQ    <= '0;
      lviQ    <= '0;
      countQ  <= '0;
      runQ    <= 1'b0;
      lastEnQ <= 1'b0;
      doneEnQ <= 1'b0;
      statusQ <= ST_W'(1);
      irqQ    <= 1'b0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (strobes.baseByteEn[b] && b * 8 < ADDR_W)
          baseQ[b*8 +: 8] <= regWrData[b*8 +: 8];
      baseQ[DESC_SHIFT-1:0] <= '0;
      if (strobes.wrLvi)  lviQ <= regWrData[8 +: IDX_W];
      if (strobes.wrCtrl) runQ <= regWrData[24];
      lastEnQ <= lastEnD;
      doneEnQ <= doneEnD;
      if (strobes.advance) begin
        civQ <= pivQ;
        pivQ <= pivQ + 1'b1;
      end else if (strobes.start) begin
        civQ <= '0;
        pivQ <= IDX_W'(1);
      end
      if (strobes.loadCount) countQ <= rspCount;
      statusQ <= statusD;
      irqQ    <= irqD;
    end
  end

  assign haltedQ     = statusQ[ST_HALTED];
  assign irq         = irqQ;
  assign descReqAddr = baseQ + (ADDR_W'(civQ) << DESC_SHIFT) + ADDR_W'(CTRL_OFF);

  always_comb begin
    unique case (regDword)
      2'd0:    regRdData = 32'(baseQ);
      2'd1:    regRdData = {4'b0, doneEnQ, lastEnQ, 1'b0, runQ,
                            {IDX_PAD{1'b0}}, pivQ, {IDX_PAD{1'b0}}, lviQ,
                            {IDX_PAD{1'b0}}, civQ};
      2'd2:    regRdData = {countQ, {(16 - ST_W){1'b0}}, statusQ};
      default: regRdData = '0;
    endcase
  end

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stop |=> haltedQ); // R5

  AST_START_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start && !strobes.advance |=> civQ == '0 && pivQ == IDX_W'(1) && !haltedQ); // R5

  AST_REG_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regReset |=> statusQ == ST_W'(1) && civQ == '0 && !irq); // R6

  AST_ADVANCE_PIV: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> civQ == $past(pivQ)); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $stable(statusQ[ST_FIFOERR:ST_LASTBUF]) |-> $stable(irq)); // R11

endmodule

// File: rtl/desc_ring_channel.sv
module desc_ring_channel
  import desc_ring_pkg::*;
#(
  parameter int RING_DEPTH = 32,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regDword,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              bufDone,
  input  logic              fifoErr,
  output logic              descReqValid,
  output logic [ADDR_W-1:0] descReqAddr,
  input  logic              descRspValid,
  input  logic [31:0]       descRspData,
  output logic              irq
);

  localparam int IDX_W = $clog2(RING_DEPTH);

  chanStrobes_t     strobes;
  logic             runQ, haltedQ;
  logic [IDX_W-1:0] civQ, lviQ;
  logic             unusedRsp;

  assign unusedRsp = ^descRspData[30:CNT_W];

  desc_ring_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regDword     (regDword),
    .regByteEn    (regByteEn),
    .wrRun        (regWrData[24]),
    .wrRegReset   (regWrData[25]),
    .wrW1c        (regWrData[4:2]),
    .wrLviVal     (regWrData[8 +: IDX_W]),
    .bufDone      (bufDone),
    .descRspValid (descRspValid),
    .rspIoc       (descRspData[31]),
    .runQ         (runQ),
    .haltedQ      (haltedQ),
    .civQ         (civQ),
    .lviQ         (lviQ),
    .strobes      (strobes),
    .descReqValid (descReqValid)
  );

  desc_ring_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regDword    (regDword),
    .regWrData   (regWrData),
    .rspCount    (descRspData[CNT_W-1:0]),
    .fifoErr     (fifoErr),
    .regRdData   (regRdData),
    .descReqAddr (descReqAddr),
    .runQ        (runQ),
    .haltedQ     (haltedQ),
    .civQ        (civQ),
    .lviQ        (lviQ),
    .irq         (irq)
  );

endmodule

// File: tb/tb_desc_ring_channel.sv
module tb_desc_ring_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regDword = 2'd0;
  logic [3:0]  regByteEn = 4'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        bufDone = 1'b0;
  logic        fifoErr = 1'b0;
  logic        descReqValid;
  logic [31:0] descReqAddr;
  logic        descRspValid = 1'b0;
  logic [31:0] descRspData = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  desc_ring_channel dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regDword(regDword),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .bufDone(bufDone), .fifoErr(fifoErr), .descReqValid(descReqValid),
    .descReqAddr(descReqAddr), .descRspValid(descRspValid),
    .descRspData(descRspData), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  dw;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  rdDw;
    logic [31:0] mask;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 4'hF, 32'h5555_555F, 2'd0, 32'hFFFF_FFFF, 32'h5555_5558}, // R2 low bits forced
    '{2'd0, 4'h1, 32'h0000_00AB, 2'd0, 32'hFFFF_FFFF, 32'h5555_55A8}, // R2 byte enable
    '{2'd1, 4'h2, 32'h0000_2500, 2'd1, 32'h0000_FF00, 32'h0000_0500}, // R3 modulo 32
    '{2'd1, 4'h5, 32'h0011_0007, 2'd1, 32'h00FF_00FF, 32'h0000_0000}, // R3 indices read-only
    '{2'd2, 4'hF, 32'hFFFF_FFFF, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001}, // R4 count and bits 0/1 ignore
    '{2'd1, 4'h2, 32'h0000_1F00, 2'd1, 32'h0000_FF00, 32'h0000_1F00}, // R3 top index
    '{2'd1, 4'h2, 32'h0000_4300, 2'd1, 32'h0000_FF00, 32'h0000_0300}  // R3 wrap
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] dw, input logic [3:0] be, input logic [31:0] d);
    regWrEn = 1'b1; regDword = dw; regByteEn = be; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = 4'h0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] dw, output logic [31:0] d);
    regDword = dw;
    #1 d = regRdData;
  endtask

  task automatic chkReg(input string tag, input logic [1:0] dw, input logic [31:0] exp);
    logic [31:0] d;
    rd(dw, d);
    check(tag, d, exp);
  endtask

  task automatic pulseDone();
    bufDone = 1'b1;
    @(negedge clk);
    bufDone = 1'b0;
  endtask

  task automatic respond(input string tag, input logic [31:0] expAddr, input logic [31:0] d);
    check({tag, " request valid"}, {31'b0, descReqValid}, 32'd1);
    check({tag, " request address"}, descReqAddr, expAddr);
    descRspValid = 1'b1; descRspData = d;
    @(negedge clk);
    descRspValid = 1'b0; descRspData = '0;
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkReg("R1 base", 2'd0, 32'h0);
    chkReg("R1 indices/control", 2'd1, 32'h0);
    chkReg("R1 status/count", 2'd2, 32'h0000_0001);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 no request", {31'b0, descReqValid}, 32'd0);

    // Register-access vectors: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] d;
      wr(VECS[i].dw, VECS[i].be, VECS[i].data);
      rd(VECS[i].rdDw, d);
      check($sformatf("R2/R3/R4 vector %0d", i), d & VECS[i].mask, VECS[i].exp);
    end

    // R5 start: base 0x1000, last valid 2, run with both enables
    wr(2'd0, 4'hF, 32'h0000_1000);
    wr(2'd1, 4'h2, 32'h0000_0200);
    wr(2'd1, 4'h8, 32'h0D00_0000);
    chkReg("R5 start indices", 2'd1, 32'h0D01_0200);
    chkReg("R5 start clears halted", 2'd2, 32'h0);

    // R7 R8 completion with interrupt request, not at last
    pulseDone();
    check("R7 request raised", {31'b0, descReqValid}, 32'd1);
    repeat (2) @(negedge clk);
    check("R7 request held", {31'b0, descReqValid}, 32'd1);
    respond("R7", 32'h0000_1004, 32'h8000_0040);
    chkReg("R8 advanced", 2'd1, 32'h0D02_0201);
    check("R11 irq on buffer complete", {31'b0, irq}, 32'd1);
    respond("R8 next entry", 32'h0000_100C, 32'h0000_0020);
    chkReg("R8 count and status", 2'd2, 32'h0020_0008);

    // R4 R11 clear buffer-complete drops irq
    wr(2'd2, 4'h1, 32'h0000_0008);
    chkReg("R4 w1c", 2'd2, 32'h0020_0000);
    check("R11 irq drop", {31'b0, irq}, 32'd0);

    // R8 completion without interrupt request
    pulseDone();
    respond("R8 no ioc", 32'h0000_100C, 32'h0000_0010);
    respond("R8 no ioc next", 32'h0000_1014, 32'h0000_0030);
    chkReg("R8 no ioc indices", 2'd1, 32'h0D03_0202);
    chkReg("R8 no ioc status", 2'd2, 32'h0030_0000);

    // R9 completion at last valid
    pulseDone();
    respond("R9", 32'h0000_1014, 32'h8000_0077);
    chkReg("R9 indices held", 2'd1, 32'h0D03_0202);
    chkReg("R9 status", 2'd2, 32'h0077_000F);
    check("R9 request ends", {31'b0, descReqValid}, 32'd0);
    check("R9 irq", {31'b0, irq}, 32'd1);

    // R13 done ignored while halted
    pulseDone();
    check("R13 halted ignores done", {31'b0, descReqValid}, 32'd0);

    // R10 restart by moving last valid
    wr(2'd1, 4'h2, 32'h0000_0400);
    chkReg("R10 indices", 2'd1, 32'h0D04_0403);
    check("R10 irq unchanged", {31'b0, irq}, 32'd1);
    respond("R10 fetch", 32'h0000_101C, 32'h0000_0055);
    chkReg("R10 status/count", 2'd2, 32'h0055_000C);

    // R11 enable change alone does not move irq; fifo error re-evaluates
    wr(2'd2, 4'h1, 32'h0000_000C);
    check("R11 drop after clear", {31'b0, irq}, 32'd0);
    wr(2'd1, 4'h8, 32'h0100_0000);
    pulseDone();
    respond("R11 done", 32'h0000_101C, 32'h8000_0011);
    respond("R11 next", 32'h0000_1024, 32'h0000_0022);
    check("R11 disabled stays low", {31'b0, irq}, 32'd0);
    wr(2'd1, 4'h8, 32'h0900_0000);
    check("R11 enable alone no raise", {31'b0, irq}, 32'd0);
    fifoErr = 1'b1;
    @(negedge clk);
    fifoErr = 1'b0;
    check("R11 fifo re-evaluates", {31'b0, irq}, 32'd1);
    chkReg("R4 fifo error set", 2'd2, 32'h0022_0018);

    // R12 set and clear of buffer-complete in one cycle
    wr(2'd2, 4'h1, 32'h0000_0018);
    check("R12 pre-clear irq", {31'b0, irq}, 32'd0);
    pulseDone();
    check("R12 request address", descReqAddr, 32'h0000_1024);
    descRspValid = 1'b1; descRspData = 32'h8000_0099;
    regWrEn = 1'b1; regDword = 2'd2; regByteEn = 4'h1; regWrData = 32'h0000_0008;
    @(negedge clk);
    descRspValid = 1'b0; descRspData = '0;
    regWrEn = 1'b0; regByteEn = 4'h0; regWrData = '0;
    chkReg("R12 set wins", 2'd2, 32'h0099_000F);
    check("R12 irq", {31'b0, irq}, 32'd1);

    // R5 stop sets halted
    wr(2'd1, 4'h2, 32'h0000_0600);
    respond("R10 second restart", 32'h0000_102C, 32'h0000_0012);
    chkReg("R10 second restart status", 2'd2, 32'h0012_000C);
    wr(2'd1, 4'h8, 32'h0800_0000);
    chkReg("R5 stop halts", 2'd2, 32'h0012_000D);
    check("R6 irq before reset", {31'b0, irq}, 32'd1);

    // R6 reset registers
    wr(2'd1, 4'h8, 32'h0200_0000);
    chkReg("R6 base", 2'd0, 32'h0);
    chkReg("R6 indices/control", 2'd1, 32'h0);
    chkReg("R6 status", 2'd2, 32'h0000_0001);
    check("R6 irq drops", {31'b0, irq}, 32'd0);

    // R13 done ignored while not running
    pulseDone();
    check("R13 stopped ignores done", {31'b0, descReqValid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule